// File: doc/BRIEF.md
# Vetoed Timestamp Clock and Dead-Time Scaler Core

This block runs entirely on one system clock (nominally 40 MHz). It produces a timestamp clock for distribution to other timestamp modules and a low-rate pulser. It also keeps four wrapping event counters, from which acquisition dead time can be measured. A busy flag stands for the acquisition being unable to accept events. A live trigger sets the flag, and a clear-busy pulse drops it.

While busy is high the timestamp clock is suppressed, and so is a vetoed copy of the pulser. The ratio of vetoed to free pulser counts therefore gives the live fraction directly, and it is not disturbed by double triggering on the raw input. The timestamp source is either an internal divide-by-`CLK_DIV` clock or an external clock. The external clock is synchronized into the system domain and its rising edges are turned into single-cycle enables. A two-bit select reads any of the four counters combinationally.

Top module: `ts_deadtime`

## Requirements
- R1: With `ext_sel_i` low and busy low, `ts_tick_o` pulses exactly once every `CLK_DIV` cycles, and `ts_clk_o` is high for `CLK_DIV/2` of every `CLK_DIV` cycles.
- R2: One cycle after busy is seen high, `ts_tick_o` and `ts_clk_o` are both low, and they stay low while busy remains high.
- R3: With `ext_sel_i` high, `ts_tick_o` pulses once for each rising edge of `ext_clk_i`, `SYNC_STAGES + 1` cycles after it.
- R4: With `ext_sel_i` high and busy low, `ts_clk_o` reproduces the level of `ext_clk_i` delayed by `SYNC_STAGES + 1` cycles.
- R5: `pulse_o` is high for exactly one cycle out of every `PULSE_DIV` cycles, independent of busy.
- R6: `pulse_veto_o` equals `pulse_o` AND NOT `busy_o` in every cycle.
- R7: `rd_data_o` shows the counter picked by `rd_sel_i`: 0 = raw triggers, 1 = live triggers, 2 = free pulser, 3 = vetoed pulser. Each counter advances by one for each cycle in which its event is present.
- R8: A rising edge on `trig_i` counts once as a raw trigger, whatever the length of the pulse.
- R9: A raw trigger edge while busy is low is a live trigger: `live_o` pulses, the live counter advances, and busy rises on the next cycle. Busy then holds until `clr_busy_i` is sampled high. Raw edges while busy is high are not live.
- R10: `clr_module_i` sets all four counters to zero and drops busy on the next cycle. It takes priority over any increment in the same cycle.
- R11: Counters are `SCALER_W` bits wide and wrap to zero after the all-ones value.
- R12: After reset, busy is low and all four counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Raw trigger, synchronous level |
| clr_busy_i | input | 1 | Drops the busy flag |
| clr_module_i | input | 1 | Zeroes counters and drops busy |
| ext_sel_i | input | 1 | 1 = external timestamp source |
| ext_clk_i | input | 1 | External timestamp clock, asynchronous |
| rd_sel_i | input | 2 | Counter select |
| rd_data_o | output | SCALER_W | Selected counter value |
| busy_o | output | 1 | Acquisition busy flag |
| live_o | output | 1 | Live trigger pulse |
| ts_clk_o | output | 1 | Vetoed timestamp clock level |
| ts_tick_o | output | 1 | Vetoed timestamp rising-edge enable |
| pulse_o | output | 1 | Free-running pulser |
| pulse_veto_o | output | 1 | Busy-vetoed pulser |

## Verification
The assertions take `trig_i`, `clr_busy_i` and `clr_module_i` to be synchronous to the system clock. They take `ext_clk_i` to change no faster than every few cycles, so that each edge survives the synchronizer. They also assume `clr_module_i` and a trigger edge never coincide when the busy checks apply. The stimulus drives every control input at the falling edge. It holds the external clock for five cycles per phase and separates trigger pulses by at least two idle cycles. The bench uses a small configuration with a 40-cycle pulser and 8-bit counters, so the wrap can be reached.

// File: rtl/ts_deadtime_pkg.sv
package ts_deadtime_pkg;
   localparam int NUM_SCALERS = 4;
   localparam int SEL_W       = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_RAW  = 2'd0,
      SEL_LIVE = 2'd1,
      SEL_FREE = 2'd2,
      SEL_VETO = 2'd3
   } scaler_sel_e;
endpackage

// File: rtl/ts_edge_rise.sv
module ts_edge_rise (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic rise_o
);
   logic d_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) d_q <= 1'b0;
      else         d_q <= d_i;
   end

   assign rise_o = d_i & ~d_q;

   // R8: a rising edge cannot repeat on the very next cycle
   assert_single_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);
endmodule

// File: rtl/ts_clk_src.sv
module ts_clk_src #(
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ext_sel_i,
   input  logic ext_clk_i,
   input  logic veto_i,
   output logic ts_clk_o,
   output logic ts_tick_o
);
   localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [PW-1:0] PH_LAST = PW'(CLK_DIV - 1);
   localparam logic [PW-1:0] PH_HALF = PW'(CLK_DIV / 2);

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // internal divider
   logic [PW-1:0] phase_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               phase_q <= '0;
      else if (phase_q == PH_LAST) phase_q <= '0;
      else                       phase_q <= phase_q + 1'b1;
   end

   logic int_level, int_rise;
   assign int_level = (phase_q < PH_HALF);
   assign int_rise  = (phase_q == '0);

   // external synchronizer plus one stage for edge detection
   logic [SYNC_STAGES:0] chain_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[SYNC_STAGES-1:0], ext_clk_i};
   end

   logic ext_level, ext_rise;
   assign ext_level = chain_q[SYNC_STAGES-1];
   assign ext_rise  = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

   logic src_level, src_rise;
   assign src_level = ext_sel_i ? ext_level : int_level;
   assign src_rise  = ext_sel_i ? ext_rise  : int_rise;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ts_clk_o  <= 1'b0;
         ts_tick_o <= 1'b0;
      end else begin
         ts_clk_o  <= src_level & ~veto_i;
         ts_tick_o <= src_rise  & ~veto_i;
      end
   end

   // R3: a synchronized external edge lasts a single cycle
   assert_ext_edge_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_rise |=> !ext_rise);
   // R1: internal edge enables are never back to back
   assert_int_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int_rise |=> !int_rise);
endmodule

// File: rtl/ts_pulser.sv
module ts_pulser #(
   parameter int PULSE_DIV = 4000
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic pulse_o
);
   localparam int CW = (PULSE_DIV > 1) ? $clog2(PULSE_DIV) : 1;
   localparam logic [CW-1:0] C_LAST = CW'(PULSE_DIV - 1);

   if (PULSE_DIV < 2) begin : g_bad_pdiv
      $error("PULSE_DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (cnt_q == C_LAST) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign pulse_o = (cnt_q == C_LAST);

   // R5: the pulse is one cycle wide
   assert_pulse_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/ts_scaler.sv
module ts_scaler #(
   parameter int W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   if (W < 2) begin : g_bad_w
      $error("scaler width must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_o <= '0;
      else if (clr_i) cnt_o <= '0;
      else if (inc_i) cnt_o <= cnt_o + 1'b1;
   end

   // R10: clearing wins over counting
   assert_clear_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_o == '0));
   // R7: without an event the count holds
   assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/ts_deadtime.sv
module ts_deadtime
   import ts_deadtime_pkg::*;
#(
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_DIV   = 4000,
   parameter int SCALER_W    = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                trig_i,
   input  logic                clr_busy_i,
   input  logic                clr_module_i,
   input  logic                ext_sel_i,
   input  logic                ext_clk_i,
   input  logic [SEL_W-1:0]    rd_sel_i,
   output logic [SCALER_W-1:0] rd_data_o,
   output logic                busy_o,
   output logic                live_o,
   output logic                ts_clk_o,
   output logic                ts_tick_o,
   output logic                pulse_o,
   output logic                pulse_veto_o
);
   logic raw_rise, live, busy_q, pulse_free, pulse_vetoed;

   ts_edge_rise u_trig_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (trig_i),
      .rise_o (raw_rise)
   );

   assign live = raw_rise & ~busy_q;

   // busy: set by live trigger, held until clear-busy, dropped by module clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           busy_q <= 1'b0;
      else if (clr_module_i) busy_q <= 1'b0;
      else if (live)         busy_q <= 1'b1;
      else if (clr_busy_i)   busy_q <= 1'b0;
   end

   ts_clk_src #(
      .CLK_DIV     (CLK_DIV),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_clk_src (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ext_sel_i (ext_sel_i),
      .ext_clk_i (ext_clk_i),
      .veto_i    (busy_q),
      .ts_clk_o  (ts_clk_o),
      .ts_tick_o (ts_tick_o)
   );

   ts_pulser #(
      .PULSE_DIV (PULSE_DIV)
   ) u_pulser (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pulse_o (pulse_free)
   );

   assign pulse_vetoed = pulse_free & ~busy_q;

   logic [NUM_SCALERS-1:0] inc;
   always_comb begin
      inc           = '0;
      inc[SEL_RAW]  = raw_rise;
      inc[SEL_LIVE] = live;
      inc[SEL_FREE] = pulse_free;
      inc[SEL_VETO] = pulse_vetoed;
   end

   logic [SCALER_W-1:0] cnt [NUM_SCALERS];

   for (genvar i = 0; i < NUM_SCALERS; i++) begin : g_scaler
      ts_scaler #(
         .W (SCALER_W)
      ) u_scaler (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .clr_i  (clr_module_i),
         .inc_i  (inc[i]),
         .cnt_o  (cnt[i])
      );
   end

   scaler_sel_e sel;
   assign sel          = scaler_sel_e'(rd_sel_i);
   assign rd_data_o    = cnt[sel];
   assign busy_o       = busy_q;
   assign live_o       = live;
   assign pulse_o      = pulse_free;
   assign pulse_veto_o = pulse_vetoed;

   // R9: a live trigger raises busy on the next cycle
   assert_live_sets_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && !clr_module_i) |=> busy_o);
   // R10: module clear drops busy
   assert_clear_drops_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_module_i |=> !busy_o);
   // R2: the timestamp outputs are silent one cycle after busy
   assert_veto_ts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |=> (!ts_tick_o && !ts_clk_o));
   // R9: without live trigger or clear, busy high stays high
   assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && !clr_busy_i && !clr_module_i) |=> busy_q);
endmodule

// File: tb/ts_deadtime_test.sv
module ts_deadtime_test;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_DIV    = 4;
   localparam int SYNC       = 2;
   localparam int PDIV       = 40;
   localparam int SW         = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig = 1'b0, clr_busy = 1'b0, clr_mod = 1'b0;
   logic ext_sel = 1'b0, ext_clk = 1'b0;
   logic [1:0] rd_sel = 2'd0;
   logic [SW-1:0] rd_data;
   logic busy, live, ts_clk, ts_tick, pulse, pulse_veto;

   always #(CLK_PERIOD/2) clk = ~clk;

   ts_deadtime #(
      .CLK_DIV     (CLK_DIV),
      .SYNC_STAGES (SYNC),
      .PULSE_DIV   (PDIV),
      .SCALER_W    (SW)
   ) uut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .trig_i       (trig),
      .clr_busy_i   (clr_busy),
      .clr_module_i (clr_mod),
      .ext_sel_i    (ext_sel),
      .ext_clk_i    (ext_clk),
      .rd_sel_i     (rd_sel),
      .rd_data_o    (rd_data),
      .busy_o       (busy),
      .live_o       (live),
      .ts_clk_o     (ts_clk),
      .ts_tick_o    (ts_tick),
      .pulse_o      (pulse),
      .pulse_veto_o (pulse_veto)
   );

   int errors = 0, checks = 0;
   bit done = 1'b0;
   int tick_acc = 0, hi_acc = 0;
   int exp_free = 0, exp_veto = 0;
   int gap = -1, spacing_err = 0, veto_mis = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // every waited cycle is sampled here, at the falling edge
   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         tick_acc += int'(ts_tick);
         hi_acc   += int'(ts_clk);
         exp_free += int'(pulse);
         exp_veto += int'(pulse && !busy);
         if (pulse_veto != (pulse && !busy)) veto_mis++;
         if (gap >= 0) gap++;
         if (pulse) begin
            if (gap >= 0 && gap != PDIV) spacing_err++;
            gap = 0;
         end
         @(negedge clk);
      end
   endtask

   task automatic clear_all();
      clr_mod = 1'b1;
      if (gap >= 0) gap++;
      if (pulse) gap = 0;
      @(negedge clk);
      clr_mod  = 1'b0;
      exp_free = 0;
      exp_veto = 0;
   endtask

   task automatic read(input int sel, output int val);
      rd_sel = 2'(sel);
      #1;
      val = int'(rd_data);
   endtask

   task automatic pulse_trig(input int len);
      trig = 1'b1;
      run(len);
      trig = 1'b0;
      run(2);
   endtask

   task automatic pulse_clr_busy();
      clr_busy = 1'b1;
      run(1);
      clr_busy = 1'b0;
      run(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      int v, exp_raw, exp_live;
      bit exp_busy;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      chk("R12 busy after reset", int'(busy), 0);
      for (int s = 0; s < 4; s++) begin
         read(s, v);
         chk("R12 counter zero after reset", v, 0);
      end

      // R1 internal source, not busy
      run(8);
      tick_acc = 0; hi_acc = 0;
      run(100 * CLK_DIV);
      chk("R1 internal tick count", tick_acc, 100);
      chk("R1 internal high cycles", hi_acc, 100 * CLK_DIV / 2);

      // R3/R4 external source
      ext_sel = 1'b1;
      run(8);
      tick_acc = 0; hi_acc = 0;
      for (int e = 0; e < 10; e++) begin
         ext_clk = 1'b1; run(5);
         ext_clk = 1'b0; run(5);
      end
      run(SYNC + 4);
      chk("R3 external tick count", tick_acc, 10);
      chk("R4 external high cycles", hi_acc, 50);
      ext_sel = 1'b0;
      run(8);

      // R2 veto of the timestamp clock
      clear_all();
      pulse_trig(1);
      chk("R9 busy after live trigger", int'(busy), 1);
      run(3);
      tick_acc = 0; hi_acc = 0;
      run(100 * CLK_DIV);
      chk("R2 vetoed ticks", tick_acc, 0);
      chk("R2 vetoed high cycles", hi_acc, 0);
      pulse_clr_busy();
      run(4);
      tick_acc = 0;
      run(20 * CLK_DIV);
      chk("R2 ticks resume after clear", tick_acc, 20);

      // R5/R6/R7 pulser, never busy
      clear_all();
      run(10 * PDIV);
      read(2, v); chk("R5 free pulser count", v, 10);
      read(3, v); chk("R6 vetoed pulser count idle", v, 10);

      // busy for the whole window
      clear_all();
      pulse_trig(1);
      run(10 * PDIV - 3);
      read(2, v); chk("R7 free pulser count busy", v, 10);
      read(3, v); chk("R6 vetoed pulser count busy", v, exp_veto);
      chk("R6 vetoed pulses at most one", int'(exp_veto <= 1), 1);

      // busy part of the window
      clear_all();
      pulse_trig(1);
      run(5 * PDIV);
      pulse_clr_busy();
      run(5 * PDIV);
      read(2, v); chk("R7 free pulser count mixed", v, exp_free);
      read(3, v); chk("R6 vetoed pulser count mixed", v, exp_veto);
      chk("R5 pulser spacing errors", spacing_err, 0);
      chk("R6 per-cycle veto mismatches", veto_mis, 0);

      // R8/R9 trigger sweep over pulse lengths and busy states
      clear_all();
      exp_raw = 0; exp_live = 0; exp_busy = 1'b0;
      for (int i = 0; i < 12; i++) begin
         pulse_trig((i % 4) + 1);
         exp_raw++;
         if (!exp_busy) begin
            exp_live++;
            exp_busy = 1'b1;
         end
         chk("R9 busy after trigger", int'(busy), int'(exp_busy));
         if (i % 3 == 2) begin
            pulse_clr_busy();
            exp_busy = 1'b0;
            chk("R9 busy after clear-busy", int'(busy), 0);
         end
      end
      read(0, v); chk("R8 raw trigger count", v, exp_raw);
      read(1, v); chk("R9 live trigger count", v, exp_live);

      // R10 module clear
      pulse_trig(2);
      chk("R9 busy set before module clear", int'(busy), 1);
      clear_all();
      chk("R10 busy after module clear", int'(busy), 0);
      for (int s = 0; s < 4; s++) begin
         read(s, v);
         chk("R10 counter zero after module clear", v, 0);
      end

      // R11 wrap
      for (int i = 0; i < 260; i++) pulse_trig(1);
      read(0, v); chk("R11 raw counter wrap", v, 260 % (1 << SW));
      read(1, v); chk("R11 live count while held busy", v, 1);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule